// File: doc/BRIEF.md
# Key-Locked System Control Register File

This block is a bank of 32-bit control and status words that sits in a 4 KiB byte-addressed window and is reached through a single-beat bus made of a valid strobe, a write flag, an address and write data. The bank comes out of reset locked. While it is locked, writes to the configuration words are thrown away and a locked-write error pulse is raised. Software changes the lock state by writing an exact 16-bit key to one of two dedicated key addresses. One scratch word is exempt from the lock, and it keeps only its least significant bit.

Every mapped address has one access class: read-write, read-only or write-only. Every other address in the window is unmapped. A read of a write-only or unmapped address, or a write to a read-only or unmapped address, raises an access error pulse. The bank still answers such a read with the stored word, or with zero where no storage exists. When software writes a word with bit 0 set to the reset control register while the bank is unlocked, the word is stored and a one-cycle system reset request is issued. Only a representative subset of words is implemented, and no clocks or pins are modelled.

Top module: `sysctl_lock_regs`

## Requirements
- R1: After reset, the lock state reads 1 at byte offset 0x00C. The PLL control words at 0x100, 0x104 and 0x108 read 0x0001A008, PLL status at 0x10C reads 0x0000003F, and boot mode at 0x25C reads 0x00000001.
- R2: A write to 0x004 sets the lock state to 1 only when write data bits [15:0] equal 0x767B, whatever the upper bits hold. Any other value leaves the state unchanged.
- R3: A write to 0x008 clears the lock state to 0 only when write data bits [15:0] equal 0xDF0D, whatever the upper bits hold. Any other value leaves the state unchanged.
- R4: While the bank is locked, a write to any read-write or write-only word other than 0x000 is discarded. The locked-write error output is high for the one cycle after that write, and the access error output stays low.
- R5: The word at 0x000 accepts writes while the bank is locked. It stores only bit 0 of the write data and reads bits [31:1] as zero.
- R6: While the bank is unlocked, a write to a read-write word stores all 32 bits. A read returns the data, with the read-valid output high, in the cycle after the access is sampled.
- R7: A write to a read-only word (0x00C, 0x10C, 0x25C, 0x530, 0x618) is dropped and pulses the access error output for one cycle, whether the bank is locked or not.
- R8: The write-only words at 0x60C and 0x614 store written data when the bank is unlocked. A read of any write-only address (0x004, 0x008, 0x60C, 0x614) pulses the access error output and returns the stored word, which is zero for the two key addresses.
- R9: An unmapped address in the window reads as zero and raises the access error pulse. A write to an unmapped address changes nothing and also raises the access error pulse.
- R10: A write to 0x200 while unlocked stores the word. If bit 0 of the data is 1, the system reset request output is high for exactly one cycle after the write. A locked write, or data with bit 0 clear, raises no request.
- R11: The error outputs and the read-valid output return low in the cycle after an idle bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address in the window; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered and held until the next read |
| rd_valid | output | 1 | High for one cycle after a read is sampled |
| err_access | output | 1 | Access class violation pulse |
| err_locked | output | 1 | Write discarded by the lock pulse |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
Every result of an access is registered once. Read data, read-valid, both error pulses and the reset request are all due in the cycle that follows the clock edge at which the access is sampled. A stored value or a lock change becomes visible to a read issued on the next cycle. The bench drives each access on the falling edge and samples 1 ns after the rising edge that takes it in. It then samples again one idle cycle later to confirm that every pulse has cleared.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  localparam int SLOTS  = 14;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;

  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'h767B;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hDF0D;

  localparam int SL_SCRATCH = 0;
  localparam int SL_PLLCTL0 = 1;
  localparam int SL_PLLSTAT = 4;
  localparam int SL_PLLCFG0 = 5;
  localparam int SL_RSTCTL  = 8;
  localparam int SL_BOOT    = 9;
  localparam int SL_IDENT   = 10;
  localparam int SL_CALGO   = 11;
  localparam int SL_REFGO   = 12;
  localparam int SL_CMDSTAT = 13;

  function automatic logic [DATA_W-1:0] slot_init(int idx, logic [DATA_W-1:0] ident);
    if (idx >= SL_PLLCTL0 && idx < SL_PLLCTL0 + 3) return 32'h0001_A008;
    if (idx >= SL_PLLCFG0 && idx < SL_PLLCFG0 + 3) return 32'h0001_4000;
    if (idx == SL_PLLSTAT) return 32'h0000_003F;
    if (idx == SL_BOOT)    return 32'h0000_0001;
    if (idx == SL_IDENT)   return ident;
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] slot_mask(int idx);
    return (idx == SL_SCRATCH) ? 32'h0000_0001 : '1;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc,
  output logic              hit_slot,
  output logic [SLOT_W-1:0] slot,
  output logic              is_close,
  output logic              is_open,
  output logic              is_state,
  output logic              lock_exempt
);
  logic [31:0] off;
  assign off = 32'(addr) & ~32'h3;

  always_comb begin
    acc = ACC_NONE; hit_slot = 1'b0; slot = '0;
    is_close = 1'b0; is_open = 1'b0; is_state = 1'b0; lock_exempt = 1'b0;
    case (off)
      32'h000: begin acc = ACC_RW; hit_slot = 1'b1; slot = SLOT_W'(SL_SCRATCH); lock_exempt = 1'b1; end
      32'h004: begin acc = ACC_WO; is_close = 1'b1; end
      32'h008: begin acc = ACC_WO; is_open = 1'b1; end
      32'h00C: begin acc = ACC_RO; is_state = 1'b1; end
      32'h100, 32'h104, 32'h108: begin
        acc = ACC_RW; hit_slot = 1'b1; slot = SLOT_W'(SL_PLLCTL0 + int'(off[3:2]));
      end
      32'h10C: begin acc = ACC_RO; hit_slot = 1'b1; slot = SLOT_W'(SL_PLLSTAT); end
      32'h110, 32'h114, 32'h118: begin
        acc = ACC_RW; hit_slot = 1'b1; slot = SLOT_W'(SL_PLLCFG0 + int'(off[3:2]));
      end
      32'h200: begin acc = ACC_RW; hit_slot = 1'b1; slot = SLOT_W'(SL_RSTCTL);  end
      32'h25C: begin acc = ACC_RO; hit_slot = 1'b1; slot = SLOT_W'(SL_BOOT);    end
      32'h530: begin acc = ACC_RO; hit_slot = 1'b1; slot = SLOT_W'(SL_IDENT);   end
      32'h60C: begin acc = ACC_WO; hit_slot = 1'b1; slot = SLOT_W'(SL_CALGO);   end
      32'h614: begin acc = ACC_WO; hit_slot = 1'b1; slot = SLOT_W'(SL_REFGO);   end
      32'h618: begin acc = ACC_RO; hit_slot = 1'b1; slot = SLOT_W'(SL_CMDSTAT); end
      default: ;
    endcase
  end
endmodule

// File: rtl/sysctl_lock_ctrl.sv
module sysctl_lock_ctrl
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_fire,
  input  logic             is_close,
  input  logic             is_open,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);
  always_ff @(posedge clk) begin
    if (rst)                                     locked <= 1'b1;
    else if (wr_fire && is_close && key == KEY_CLOSE) locked <= 1'b1;
    else if (wr_fire && is_open  && key == KEY_OPEN)  locked <= 1'b0;
  end

  assert_lock_moves_on_write_R2: assert property (@(posedge clk) disable iff (rst)
    (locked != $past(locked)) |-> $past(wr_fire && (is_close || is_open)));
  assert_unlock_needs_key_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(is_open && key == KEY_OPEN));
endmodule

// File: rtl/sysctl_regstore.sv
module sysctl_regstore
  import sysctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDENT = 32'h1234_5093
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [SLOTS-1:0][DATA_W-1:0] q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                              q[g] <= slot_init(g, IDENT);
      else if (we && slot == SLOT_W'(g))   q[g] <= wdata & slot_mask(g);
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < SLOTS; i++)
      if (slot == SLOT_W'(i)) rdata = q[i];
  end

  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/sysctl_lock_regs.sv
module sysctl_lock_regs
  import sysctl_pkg::*;
#(
  parameter int                WIN_BYTES = 4096,
  parameter logic [DATA_W-1:0] IDENT     = 32'h1234_5093,
  localparam int               ADDR_W    = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err_access,
  output logic              err_locked,
  output logic              sys_reset_req
);
  acc_e              acc;
  logic              hit_slot, is_close, is_open, is_state, lock_exempt, locked;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] slot_rd, rd_word;
  logic              wr_fire, rd_fire, bad_class, wr_legal, store_en, lock_block;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .acc(acc), .hit_slot(hit_slot), .slot(slot),
    .is_close(is_close), .is_open(is_open), .is_state(is_state),
    .lock_exempt(lock_exempt));

  assign wr_fire   = bus_valid && bus_write;
  assign rd_fire   = bus_valid && !bus_write;
  assign bad_class = (acc == ACC_NONE) || (bus_write && acc == ACC_RO) ||
                     (!bus_write && acc == ACC_WO);
  assign wr_legal  = wr_fire && !bad_class && hit_slot;
  assign lock_block = locked && !lock_exempt;
  assign store_en  = wr_legal && !lock_block;

  sysctl_lock_ctrl u_lock (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .is_close(is_close),
    .is_open(is_open), .key(bus_wdata[KEY_W-1:0]), .locked(locked));

  sysctl_regstore #(.IDENT(IDENT)) u_store (
    .clk(clk), .rst(rst), .we(store_en), .slot(slot),
    .wdata(bus_wdata), .rdata(slot_rd));

  assign rd_word = is_state ? DATA_W'(locked) : (hit_slot ? slot_rd : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0; rd_valid <= 1'b0; err_access <= 1'b0;
      err_locked <= 1'b0; sys_reset_req <= 1'b0;
    end else begin
      rd_valid      <= rd_fire;
      err_access    <= bus_valid && bad_class;
      err_locked    <= wr_legal && lock_block;
      sys_reset_req <= store_en && slot == SLOT_W'(SL_RSTCTL) && bus_wdata[0];
      if (rd_fire) rd_data <= rd_word;
    end
  end

  assert_req_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |=> !sys_reset_req);
  assert_req_only_unlocked_R10: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(!locked && bus_write));
  assert_errors_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(err_access && err_locked));
  assert_rd_valid_follows_read_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_valid && !bus_write));
  assert_idle_clears_flags_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !(rd_valid || err_access || err_locked || sys_reset_req));
endmodule

// File: tb/sysctl_lock_regs_tb.sv
`timescale 1ns/1ps
module sysctl_lock_regs_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, err_access, err_locked, sys_reset_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sysctl_lock_regs u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .err_access(err_access), .err_locked(err_locked),
    .sys_reset_req(sys_reset_req));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; outputs sampled 1 ns after the capturing edge
  task automatic access(bit wr, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic idle_clear(string req);
    @(negedge clk); @(posedge clk); #1;
    chk(req, {rd_valid, err_access, err_locked, sys_reset_req}, 4'b0);
  endtask

  task automatic rd_expect(string req, logic [11:0] a, logic [31:0] exp, bit exp_err);
    access(1'b0, a, '0);
    chk(req, rd_data, exp);
    chk(req, {rd_valid, err_access}, {1'b1, exp_err});
  endtask

  task automatic t_reset_state;                      // R1
    rd_expect("R1", 12'h00C, 32'h1, 1'b0);
    rd_expect("R1", 12'h100, 32'h0001A008, 1'b0);
    rd_expect("R1", 12'h108, 32'h0001A008, 1'b0);
    rd_expect("R1", 12'h10C, 32'h0000003F, 1'b0);
    rd_expect("R1", 12'h25C, 32'h1, 1'b0);
  endtask

  task automatic t_locked_write;                     // R4, R11
    access(1'b1, 12'h104, 32'h12345678);
    chk("R4", {err_locked, err_access}, 2'b10);
    idle_clear("R11");
    rd_expect("R4", 12'h104, 32'h0001A008, 1'b0);
  endtask

  task automatic t_scratch;                          // R5
    access(1'b1, 12'h000, 32'hFFFFFFFE);
    chk("R5", err_locked, 1'b0);
    rd_expect("R5", 12'h000, 32'h0, 1'b0);
    access(1'b1, 12'h000, 32'hF0000003);
    rd_expect("R5", 12'h000, 32'h1, 1'b0);
  endtask

  task automatic t_unlock;                           // R3
    access(1'b1, 12'h008, 32'h0000DF0C);
    rd_expect("R3", 12'h00C, 32'h1, 1'b0);
    access(1'b1, 12'h008, 32'hABCDDF0D);
    rd_expect("R3", 12'h00C, 32'h0, 1'b0);
  endtask

  task automatic t_unlocked_rw;                      // R6
    access(1'b1, 12'h104, 32'hCAFEF00D);
    chk("R6", {err_locked, err_access}, 2'b00);
    rd_expect("R6", 12'h104, 32'hCAFEF00D, 1'b0);
    idle_clear("R6");
  endtask

  task automatic t_read_only;                        // R7
    access(1'b1, 12'h10C, 32'h0);
    chk("R7", {err_access, err_locked}, 2'b10);
    rd_expect("R7", 12'h10C, 32'h3F, 1'b0);
    access(1'b1, 12'h00C, 32'h1);
    chk("R7", err_access, 1'b1);
    rd_expect("R7", 12'h00C, 32'h0, 1'b0);
  endtask

  task automatic t_write_only;                       // R8
    access(1'b1, 12'h60C, 32'h55);
    chk("R8", err_access, 1'b0);
    rd_expect("R8", 12'h60C, 32'h55, 1'b1);
    rd_expect("R8", 12'h004, 32'h0, 1'b1);
  endtask

  task automatic t_unmapped;                         // R9
    rd_expect("R9", 12'h7F0, 32'h0, 1'b1);
    access(1'b1, 12'h7F0, 32'hFFFFFFFF);
    chk("R9", err_access, 1'b1);
    rd_expect("R9", 12'h7F0, 32'h0, 1'b1);
  endtask

  task automatic t_soft_reset;                       // R10
    access(1'b1, 12'h200, 32'h2);
    chk("R10", sys_reset_req, 1'b0);
    access(1'b1, 12'h200, 32'h1);
    chk("R10", sys_reset_req, 1'b1);
    idle_clear("R10");
    rd_expect("R10", 12'h200, 32'h1, 1'b0);
  endtask

  task automatic t_relock;                           // R2, R10
    access(1'b1, 12'h004, 32'h0000767A);
    rd_expect("R2", 12'h00C, 32'h0, 1'b0);
    access(1'b1, 12'h004, 32'h9999767B);
    rd_expect("R2", 12'h00C, 32'h1, 1'b0);
    access(1'b1, 12'h200, 32'h1);
    chk("R10", {sys_reset_req, err_locked}, 2'b01);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", {rd_valid, err_access, err_locked, sys_reset_req}, 4'b0);
    t_reset_state();
    t_locked_write();
    t_scratch();
    t_unlock();
    t_unlocked_rw();
    t_read_only();
    t_write_only();
    t_unmapped();
    t_soft_reset();
    t_relock();
    finish_run();
  end
endmodule